// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words and reports which one is larger through three flags: less-than, equal and greater-than, with exactly one of them raised. It is built from identical 4-bit slices. Each slice compares its own nibble pair, starting from the top bit of the nibble. When its nibble pair matches, it passes on the verdict that arrives from the slice below it.

The top module generates a chain of `NSLICES` slices, so the words are `4*NSLICES` bits wide. The chain input of the lowest slice is fixed to the "equal" verdict. The slice inputs take plain binary nibbles or BCD digits, and both are treated as unsigned 4-bit magnitudes.

The `REG_OUT` parameter selects the output path. When `REG_OUT` is set, a clock-enabled output register captures the verdict. When it is clear, the verdict reaches the ports straight from the chain. The reset is asynchronous and active-low, and the block synchronizes its release internally.

Top module: `mag_cmp_top`

## Requirements
- R1: For any operand pair, `lt` equals unsigned `a < b` and `gt` equals unsigned `a > b`. The highest bit position where `a` and `b` differ decides the result. This holds for binary and BCD nibble values alike.
- R2: When `a == b` over the full width, `eq` is 1 and `lt` and `gt` are 0.
- R3: Once the output has captured a verdict, exactly one of `lt`, `eq`, `gt` is 1.
- R4: A single slice whose two nibbles are equal drives its three flags as an exact copy of its three chain inputs {lt, eq, gt}. This includes chain inputs that are not one-hot, such as 000, 011 or 111.
- R5: A single slice whose two nibbles differ ignores its chain inputs. All eight chain input codes give the same result.
- R6: In a chain, a lower slice decides the result only when all higher nibble pairs are equal. In that case, upper slices that are equal and lower slices that differ give the verdict of the lower slices.
- R7: With `REG_OUT`=1, the inputs present at a rising clock edge with `en`=1 appear on the outputs after that edge. With `en`=0, the outputs hold their value whatever the inputs do.
- R8: While `rst_n` is low, and after reset until the first enabled edge, all three outputs are 0.
- R9: With `REG_OUT`=0, the outputs follow the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| en | input | 1 | Capture enable for the output register |
| a | input | 4*NSLICES | Operand A, unsigned |
| b | input | 4*NSLICES | Operand B, unsigned |
| lt | output | 1 | A is less than B |
| eq | output | 1 | A equals B |
| gt | output | 1 | A is greater than B |

## Verification
The combinational assertions assume that `a`, `b` and the chain inputs carry known values. They skip any evaluation in which an operand is still unknown. The clocked assertions also take the enable as a known level on every edge after the synchronized reset has released.

The bench drives every operand and enable from reset onward, so no X reaches the compare logic after the first vector. It uses fixed-seed random draws, shaped so that equal words and words that differ only in their low nibbles both occur often.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int SLICE_W = 4;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } rel_t;

  localparam rel_t REL_TIE_LOW = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};
endpackage

// File: rtl/mag_slice.sv
module mag_slice
  import cmp_pkg::*;
(
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  rel_t               casc_i,
  output rel_t               rel_o
);

  rel_t res;

  // Walk from LSB to MSB so the highest differing bit is the last to write.
  always_comb begin
    res = casc_i;
    for (int i = 0; i < SLICE_W; i++) begin
      if (a_i[i] != b_i[i]) begin
        res.lt = b_i[i];
        res.eq = 1'b0;
        res.gt = a_i[i];
      end
    end
  end

  assign rel_o = res;

  always_comb begin
    if (!$isunknown({a_i, b_i, casc_i})) begin
      if (a_i == b_i) begin
        assert_pass_through_R4: assert (rel_o == casc_i);
      end else begin
        assert_ignore_casc_R5: assert (rel_o.eq == 1'b0 && (rel_o.gt == (a_i > b_i)));
      end
    end
  end

endmodule

// File: rtl/mag_chain.sv
module mag_chain
  import cmp_pkg::*;
#(
  parameter int NSLICES = 3
) (
  input  logic [SLICE_W*NSLICES-1:0] a_i,
  input  logic [SLICE_W*NSLICES-1:0] b_i,
  output rel_t                       rel_o
);

  localparam int W = SLICE_W * NSLICES;

  rel_t link [NSLICES+1];

  assign link[0] = REL_TIE_LOW;

  for (genvar s = 0; s < NSLICES; s++) begin : g_slice
    mag_slice u_slice (
      .a_i    (a_i[s*SLICE_W +: SLICE_W]),
      .b_i    (b_i[s*SLICE_W +: SLICE_W]),
      .casc_i (link[s]),
      .rel_o  (link[s+1])
    );
  end

  assign rel_o = link[NSLICES];

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      assert_order_R1: assert (rel_o.gt == (a_i > b_i) && rel_o.lt == (a_i < b_i));
      assert_equal_R2: assert (rel_o.eq == (a_i == b_i));
      assert_single_R3: assert ($onehot(rel_o));
    end
  end

  if (W < SLICE_W) begin : g_bad_width
    initial assert_width_R1: assert (0);
  end

endmodule

// File: rtl/mag_outreg.sv
module mag_outreg
  import cmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  rel_t d_i,
  output rel_t q_o
);

  rel_t q_r;
  rel_t q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en_i) begin
      q_nxt = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign q_o = q_r;

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (q_o == $past(d_i)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(q_o));

  assert_at_most_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_o));

endmodule

// File: rtl/mag_cmp_top.sv
module mag_cmp_top
  import cmp_pkg::*;
#(
  parameter int NSLICES = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [SLICE_W*NSLICES-1:0] a,
  input  logic [SLICE_W*NSLICES-1:0] b,
  output logic                       lt,
  output logic                       eq,
  output logic                       gt
);

  rel_t chain_rel;
  rel_t out_rel;

  mag_chain #(.NSLICES(NSLICES)) u_chain (
    .a_i   (a),
    .b_i   (b),
    .rel_o (chain_rel)
  );

  if (REG_OUT) begin : g_reg
    logic [1:0] rst_sync;
    logic       rst_n_int;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rst_sync <= 2'b00;
      end else begin
        rst_sync <= {rst_sync[0], 1'b1};
      end
    end

    assign rst_n_int = rst_sync[1];

    mag_outreg u_outreg (
      .clk   (clk),
      .rst_n (rst_n_int),
      .en_i  (en),
      .d_i   (chain_rel),
      .q_o   (out_rel)
    );
  end else begin : g_comb
    assign out_rel = chain_rel;
  end

  assign lt = out_rel.lt;
  assign eq = out_rel.eq;
  assign gt = out_rel.gt;

endmodule

// File: tb/test_mag_cmp_top.sv
module test_mag_cmp_top;
  import cmp_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic en;
  always #4 clk = ~clk;

  logic [11:0] a3, b3;
  logic [7:0]  a2, b2;
  logic [3:0]  a1, b1;
  logic [7:0]  ac, bc;
  logic        lt3, eq3, gt3, lt2, eq2, gt2, lt1, eq1, gt1, ltc, eqc, gtc;
  logic [3:0]  sa, sb;
  rel_t        scasc, srel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  mag_cmp_top i_mag_cmp_top (.clk(clk), .rst_n(rst_n), .en(en), .a(a3), .b(b3),
                             .lt(lt3), .eq(eq3), .gt(gt3));
  mag_cmp_top #(.NSLICES(2)) i_mag_cmp_top_w8 (.clk(clk), .rst_n(rst_n), .en(en),
                             .a(a2), .b(b2), .lt(lt2), .eq(eq2), .gt(gt2));
  mag_cmp_top #(.NSLICES(1)) i_mag_cmp_top_w4 (.clk(clk), .rst_n(rst_n), .en(en),
                             .a(a1), .b(b1), .lt(lt1), .eq(eq1), .gt(gt1));
  mag_cmp_top #(.NSLICES(2), .REG_OUT(1'b0)) i_mag_cmp_top_comb (.clk(clk), .rst_n(rst_n),
                             .en(en), .a(ac), .b(bc), .lt(ltc), .eq(eqc), .gt(gtc));
  mag_slice i_slice (.a_i(sa), .b_i(sb), .casc_i(scasc), .rel_o(srel));

  function automatic logic [2:0] ref_rel(input logic [15:0] x, input logic [15:0] y);
    return {x < y, x == y, x > y};
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2:0] e3, e2, e1, hold3;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h1234);
    rst_n = 1'b0; en = 1'b0;
    a3 = 12'h5A5; b3 = 12'h123; a2 = 8'h10; b2 = 8'h20; a1 = 4'h3; b1 = 4'h3;
    ac = '0; bc = '0; sa = '0; sb = '0; scasc = REL_TIE_LOW;
    repeat (3) @(negedge clk);
    chk("R8 in reset", {lt3, eq3, gt3}, 3'b000);
    chk("R8 in reset w8", {lt2, eq2, gt2}, 3'b000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 after reset, no enable", {lt3, eq3, gt3}, 3'b000);
    chk("R8 after reset, no enable w4", {lt1, eq1, gt1}, 3'b000);

    // Directed first vector: captured one edge later
    en = 1'b1;
    a3 = 12'h800; b3 = 12'h7FF;
    @(negedge clk);
    chk("R7 capture R1 msb", {lt3, eq3, gt3}, 3'b001);

    // Exhaustive 4- and 8-bit sweeps, shaped random 12-bit, pipelined checks
    e3 = ref_rel({4'h0, a3}, {4'h0, b3});
    e2 = ref_rel({8'h0, a2}, {8'h0, b2});
    e1 = ref_rel({12'h0, a1}, {12'h0, b1});
    for (int v = 0; v < 65536; v++) begin
      logic [11:0] r;
      a2 = v[15:8]; b2 = v[7:0];
      a1 = v[7:4];  b1 = v[3:0];
      ac = v[15:8]; bc = v[7:0];
      r = 12'($urandom);
      a3 = r;
      case (v % 4)
        0: b3 = r;
        1: b3 = {r[11:4], 4'($urandom)};
        2: b3 = {r[11:8], 8'($urandom)};
        default: b3 = 12'($urandom);
      endcase
      #1;
      chk("R9 comb path", {ltc, eqc, gtc}, ref_rel({8'h0, ac}, {8'h0, bc}));
      @(negedge clk);
      if (v % 4 == 0) chk("R2 R3 equal 12-bit", {lt3, eq3, gt3}, ref_rel({4'h0, a3}, {4'h0, b3}));
      else if (v % 4 == 1) chk("R6 equal upper", {lt3, eq3, gt3}, ref_rel({4'h0, a3}, {4'h0, b3}));
      else chk("R1 R3 12-bit", {lt3, eq3, gt3}, ref_rel({4'h0, a3}, {4'h0, b3}));
      chk("R1 R2 exhaustive 8-bit", {lt2, eq2, gt2}, ref_rel({8'h0, a2}, {8'h0, b2}));
      chk("R1 R2 exhaustive 4-bit", {lt1, eq1, gt1}, ref_rel({12'h0, a1}, {12'h0, b1}));
    end

    // Hold with enable low
    hold3 = {lt3, eq3, gt3};
    en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      a3 = 12'($urandom); b3 = ~a3;
      @(negedge clk);
      chk("R7 hold with en low", {lt3, eq3, gt3}, hold3);
    end
    en = 1'b1;
    a3 = 12'h0F0; b3 = 12'h0F1;
    @(negedge clk);
    chk("R6 R7 lowest bit decides", {lt3, eq3, gt3}, 3'b100);

    // Slice alone: pass-through and ignored chain inputs
    for (int c = 0; c < 8; c++) begin
      for (int v = 0; v < 16; v++) begin
        scasc = rel_t'(c[2:0]);
        sa = v[3:0]; sb = v[3:0];
        #1;
        chk("R4 slice pass-through", srel, c[2:0]);
        sb = v[3:0] ^ 4'(1 + (v % 15));
        #1;
        chk("R5 slice ignores chain", srel, ref_rel({12'h0, sa}, {12'h0, sb}));
      end
    end

    // BCD digits 0..9 against each other
    for (int x = 0; x < 10; x++) begin
      for (int y = 0; y < 10; y++) begin
        ac = {4'(x), 4'(y)}; bc = {4'(y), 4'(x)};
        #1;
        chk("R1 BCD digits", {ltc, eqc, gtc}, ref_rel({8'h0, ac}, {8'h0, bc}));
      end
    end

    finish_run();
  end

endmodule